// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural integer state of a processor core. It has sixteen logical general registers, one current status word and a set of saved status words. The low five bits of the current status word give the processor mode. The mode decides which physical copy a logical register index reaches. Registers 8 to 12 have a second copy that only fast-interrupt mode uses. Registers 13 and 14 (stack pointer and link register) have one copy per exception mode, and user and system mode share one further copy. Each exception mode also owns a saved status word.

There are two combinational read ports and one write port addressed by logical index. The current status word has its own read and write port, and so does the saved status word of the current mode. Every write uses the mode that is current before the clock edge. A mode change written into the status word therefore first affects the next cycle. Mode values outside the eight legal encodings raise an error output, and in that case accesses fall back to the user and system copies. Register 15 holds the program counter. It changes only through the write port.

Top module: `bankreg_file`

## Requirements
- R1: After reset every general register and every saved status word reads zero. The status word reads 0x000001D3: supervisor mode, plus the asynchronous-abort mask (bit 8), the interrupt mask (bit 7) and the fast-interrupt mask (bit 6).
- R2: Both read ports are combinational and independent. A register written in a cycle still reads its old value during that cycle, and the new value is visible after the clock edge.
- R3: Registers 0 to 7 and register 15 are one shared copy that every mode reads and writes alike.
- R4: Registers 8 to 12 have one copy for fast-interrupt mode and one common copy for every other mode.
- R5: Registers 13 and 14 have a separate copy for each of fast-interrupt, interrupt, supervisor, monitor, abort and undefined mode. User and system mode share one copy.
- R6: Status bits [4:0] select the mode. The encodings are: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, monitor 10110, abort 10111, undefined 11011, system 11111.
- R7: The status word stores all 32 bits exactly as written. The flags sit at N=31, Z=30, C=29 and V=28. The endian bit is at 9 (1 = big-endian data). The masks are A=8, I=7 and F=6.
- R8: The saved-status port reads and writes the saved word of the current mode. Each of the six exception modes has its own word.
- R9: In user or system mode, saved-status reads return zero, saved-status writes leave every saved word unchanged, and `no_spsr` is high.
- R10: A reserved mode value drives `mode_bad` high and `no_spsr` high. Register accesses then use the user/system copies.
- R11: A general-register or saved-status write in the same cycle as a mode-changing status write goes to the copy of the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| psr_wr_en | input | 1 | Status word write enable |
| psr_wr_data | input | 32 | New status word |
| psr_rd_data | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Saved-status write enable (current mode) |
| spsr_wr_data | input | 32 | Saved-status write data |
| spsr_rd_data | output | 32 | Saved status of current mode |
| no_spsr | output | 1 | Current mode has no saved status word |
| mode_bad | output | 1 | Mode field holds a reserved value |

## Verification
The assertions watch relations that must hold on every cycle:
- both read ports agree when they address the same index;
- a written register shows the written value one cycle later when the mode is unchanged;
- an untouched register keeps its value;
- the status word captures its write;
- a mode without a saved status word reads zero;
- a reserved mode falls back to the user bank.

Only the bench scenarios can show the banking itself: which copy each mode reaches, that a fast-interrupt register 8 survives a trip through user mode, and that writes in a mode-switch cycle land in the old bank. They also show the reset image and that saved-status writes in user mode are really dropped. The bench checks these against a reference model that is organised by mode class instead of by physical slot.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int PSR_W   = 32;
  localparam int NLOG    = 16;
  localparam int IDX_W   = $clog2(NLOG);
  localparam int N_BANKS = 7;                 // user/system + six exception modes
  localparam int N_LOW   = 9;                 // R0..R7 and R15
  localparam int N_HI    = 5;                 // R8..R12
  localparam int NSLOT   = N_LOW + 2 * N_HI + 2 * N_BANKS;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int SP_BASE = N_LOW + 2 * N_HI;  // first stack/link slot

  localparam int POS_A = 8;
  localparam int POS_I = 7;
  localparam int POS_F = 6;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2, BK_SVC = 3'd3,
    BK_MON = 3'd4, BK_ABT = 3'd5, BK_UND = 3'd6
  } bank_e;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_MON = 5'b10110;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam logic [PSR_W-1:0] PSR_RESET =
    PSR_W'((1 << POS_A) | (1 << POS_I) | (1 << POS_F)) | {{(PSR_W-5){1'b0}}, M_SVC};

  // Logical index plus bank -> flat physical slot.
  function automatic logic [SLOT_W-1:0] phys_slot(input logic [IDX_W-1:0] idx, input bank_e bk);
    logic [SLOT_W-1:0] s;
    if (idx == 4'd15)
      s = SLOT_W'(N_LOW - 1);
    else if (idx < 4'd8)
      s = SLOT_W'(idx);
    else if (idx < 4'd13)
      s = (bk == BK_FIQ) ? SLOT_W'(32'(idx) - 8 + N_LOW + N_HI)
                         : SLOT_W'(32'(idx) - 8 + N_LOW);
    else
      s = SLOT_W'(SP_BASE + 2 * 32'(bk) + 32'(idx) - 13);
    return s;
  endfunction
endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
  import bankreg_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank,
  output logic       mode_bad,
  output logic       no_spsr
);
  always_comb begin
    mode_bad = 1'b0;
    unique case (mode)
      M_FIQ:        bank = BK_FIQ;
      M_IRQ:        bank = BK_IRQ;
      M_SVC:        bank = BK_SVC;
      M_MON:        bank = BK_MON;
      M_ABT:        bank = BK_ABT;
      M_UND:        bank = BK_UND;
      M_USR, M_SYS: bank = BK_USR;
      default: begin
        bank     = BK_USR;
        mode_bad = 1'b1;
      end
    endcase
  end

  assign no_spsr = (bank == BK_USR);
endmodule

// File: rtl/bankreg_gpr.sv
module bankreg_gpr
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] slot_q [NSLOT];
  logic [SLOT_W-1:0] wr_slot;

  assign wr_slot = phys_slot(wr_idx, bank);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (wr_en && wr_slot == SLOT_W'(s))
        slot_q[s] <= wr_data;
    end
  end

  assign rd_a_data = slot_q[phys_slot(rd_a_idx, bank)];
  assign rd_b_data = slot_q[phys_slot(rd_b_idx, bank)];
endmodule

// File: rtl/bankreg_psr.sv
module bankreg_psr
  import bankreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bank_e            bank,
  input  logic             psr_wr_en,
  input  logic [PSR_W-1:0] psr_wr_data,
  input  logic             spsr_wr_en,
  input  logic [PSR_W-1:0] spsr_wr_data,
  output logic [PSR_W-1:0] psr_q,
  output logic [PSR_W-1:0] spsr_rd
);
  logic [PSR_W-1:0] saved_q [1:N_BANKS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         psr_q <= PSR_RESET;
    else if (psr_wr_en) psr_q <= psr_wr_data;
  end

  // The user bank (0) owns no saved word, so its writes match no entry.
  for (genvar b = 1; b < N_BANKS; b++) begin : g_saved
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        saved_q[b] <= '0;
      else if (spsr_wr_en && bank == bank_e'(3'(b)))
        saved_q[b] <= spsr_wr_data;
    end
  end

  always_comb begin
    spsr_rd = '0;
    for (int b = 1; b < N_BANKS; b++)
      if (bank == bank_e'(3'(b))) spsr_rd = saved_q[b];
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_a_idx,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_idx,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        psr_wr_en,
  input  logic [31:0] psr_wr_data,
  output logic [31:0] psr_rd_data,
  input  logic        spsr_wr_en,
  input  logic [31:0] spsr_wr_data,
  output logic [31:0] spsr_rd_data,
  output logic        no_spsr,
  output logic        mode_bad
);
  bank_e      cur_bank;   // active bank, brought out for the checker
  logic [4:0] cur_mode;

  assign cur_mode = psr_rd_data[4:0];

  bankreg_decode u_dec (
    .mode     (cur_mode),
    .bank     (cur_bank),
    .mode_bad (mode_bad),
    .no_spsr  (no_spsr)
  );

  bankreg_gpr #(.DATA_W(32)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank      (cur_bank),
    .rd_a_idx  (rd_a_idx),
    .rd_b_idx  (rd_b_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data)
  );

  bankreg_psr u_psr (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank         (cur_bank),
    .psr_wr_en    (psr_wr_en),
    .psr_wr_data  (psr_wr_data),
    .spsr_wr_en   (spsr_wr_en),
    .spsr_wr_data (spsr_wr_data),
    .psr_q        (psr_rd_data),
    .spsr_rd      (spsr_rd_data)
  );
endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk
  import bankreg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic [3:0]  rd_b_idx,
  input logic [31:0] rd_b_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic        psr_wr_en,
  input logic [31:0] psr_wr_data,
  input logic [31:0] psr_rd_data,
  input logic [31:0] spsr_rd_data,
  input logic        no_spsr,
  input logic        mode_bad,
  input bank_e       cur_bank
);
  // R2: the two read ports see the same storage
  p_ports_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

  // R2: a write becomes visible after the edge when the mode is unchanged
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && !$past(psr_wr_en) && rd_a_idx == $past(wr_idx))
      |-> (rd_a_data == $past(wr_data)));

  // R2: with no write of any kind, a read of the same index is unchanged
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && !$past(psr_wr_en) && rd_a_idx == $past(rd_a_idx))
      |-> (rd_a_data == $past(rd_a_data)));

  // R7: the status word captures every written bit
  p_psr_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    psr_wr_en |=> (psr_rd_data == $past(psr_wr_data)));

  // R9: a mode without a saved word reads zero on that port
  p_no_saved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    no_spsr |-> (spsr_rd_data == '0));

  // R10: a reserved mode falls back to the user bank
  p_bad_user_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad |-> (no_spsr && cur_bank == BK_USR));
endmodule

bind bankreg_file bankreg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_a_idx     (rd_a_idx),
  .rd_a_data    (rd_a_data),
  .rd_b_idx     (rd_b_idx),
  .rd_b_data    (rd_b_data),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .psr_wr_en    (psr_wr_en),
  .psr_wr_data  (psr_wr_data),
  .psr_rd_data  (psr_rd_data),
  .spsr_rd_data (spsr_rd_data),
  .no_spsr      (no_spsr),
  .mode_bad     (mode_bad),
  .cur_bank     (cur_bank)
);

// File: tb/sim_bankreg_file.sv
module sim_bankreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, psr_rd_data, spsr_rd_data;
  logic        wr_en = 1'b0, psr_wr_en = 1'b0, spsr_wr_en = 1'b0;
  logic [31:0] wr_data = '0, psr_wr_data = '0, spsr_wr_data = '0;
  logic        no_spsr, mode_bad;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bankreg_file u0 (.*);

  // Reference model, organised by mode class rather than by physical slot.
  logic [31:0] m_com  [16];
  logic [31:0] m_fiq  [5];
  logic [31:0] m_sp   [7][2];
  logic [31:0] m_sav  [7];
  logic [31:0] m_psr;

  localparam logic [4:0] MODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10110, 5'b10111, 5'b11011, 5'b11111};

  // class 0 = user/system/reserved, 1 = fast int, 2..6 = other exception modes
  function automatic int cls(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10110: return 4;
      5'b10111: return 5;
      5'b11011: return 6;
      default:  return 0;
    endcase
  endfunction

  function automatic bit legal(input logic [4:0] m);
    foreach (MODES[k]) if (MODES[k] == m) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_read(input logic [3:0] i, input logic [4:0] m);
    if (i == 13 || i == 14) return m_sp[cls(m)][i - 13];
    if (i >= 8 && i <= 12 && cls(m) == 1) return m_fiq[i - 8];
    return m_com[i];
  endfunction

  task automatic ref_write(input logic [3:0] i, input logic [4:0] m, input logic [31:0] d);
    if (i == 13 || i == 14) m_sp[cls(m)][i - 13] = d;
    else if (i >= 8 && i <= 12 && cls(m) == 1) m_fiq[i - 8] = d;
    else m_com[i] = d;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // Inputs are already driven; check at the falling edge, then step the model.
  task automatic run(input string tag);
    logic [4:0] cm;
    cm = m_psr[4:0];
    #4;
    chk(tag, "rd_a", rd_a_data, ref_read(rd_a_idx, cm));
    chk(tag, "rd_b", rd_b_data, ref_read(rd_b_idx, cm));
    chk(tag, "psr", psr_rd_data, m_psr);
    chk(tag, "spsr", spsr_rd_data, cls(cm) == 0 ? 32'h0 : m_sav[cls(cm)]);
    chk(tag, "no_spsr", {31'h0, no_spsr}, {31'h0, cls(cm) == 0});
    chk(tag, "mode_bad", {31'h0, mode_bad}, {31'h0, !legal(cm)});
    @(posedge clk);
    if (wr_en) ref_write(wr_idx, cm, wr_data);
    if (spsr_wr_en && cls(cm) != 0) m_sav[cls(cm)] = spsr_wr_data;
    if (psr_wr_en) m_psr = psr_wr_data;
    #1;
    wr_en = 1'b0; psr_wr_en = 1'b0; spsr_wr_en = 1'b0;
  endtask

  task automatic go_mode(input string tag, input logic [4:0] m);
    psr_wr_en = 1'b1; psr_wr_data = {27'h0, m};
    run(tag);
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [3:0] b);
    rd_a_idx = a; rd_b_idx = b;
    run(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    foreach (m_com[k]) m_com[k] = '0;
    foreach (m_fiq[k]) m_fiq[k] = '0;
    foreach (m_sav[k]) m_sav[k] = '0;
    for (int b = 0; b < 7; b++) begin m_sp[b][0] = '0; m_sp[b][1] = '0; end
    m_psr = 32'h0000_01D3;

    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset image, all sixteen indices in supervisor mode
    for (int k = 0; k < 8; k++) rd("R1", 4'(2 * k), 4'(2 * k + 1));
    chk("R1", "psr reset", psr_rd_data, 32'h0000_01D3);

    // R2: read during the write cycle shows the old value
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'hA5A5_0005; rd_a_idx = 4'd5;
    run("R2");
    rd("R2", 4'd5, 4'd5);

    // R3: low registers and R15 shared across a mode change
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0011; run("R3");
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_8000; run("R3");
    go_mode("R3", MODES[1]);
    rd("R3", 4'd0, 4'd15);

    // R4: R8 of fast-interrupt mode is separate from the common copy
    wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'h0000_0088; run("R4");
    go_mode("R4", MODES[0]);
    rd("R4", 4'd8, 4'd12);
    wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'h0000_0C08; run("R4");
    go_mode("R4", MODES[1]);
    rd("R4", 4'd8, 4'd9);

    // R5, R6: stack and link copies per mode, walking all encodings
    foreach (MODES[k]) begin
      go_mode("R6", MODES[k]);
      wr_en = 1'b1; wr_idx = 4'd13; wr_data = {27'h5_0000, MODES[k]}; run("R5");
      wr_en = 1'b1; wr_idx = 4'd14; wr_data = {27'h7_0000, MODES[k]}; run("R5");
    end
    foreach (MODES[k]) begin
      go_mode("R6", MODES[k]);
      rd("R5", 4'd13, 4'd14);
    end

    // R8: each exception mode owns a saved word
    for (int k = 1; k < 7; k++) begin
      go_mode("R8", MODES[k]);
      spsr_wr_en = 1'b1; spsr_wr_data = 32'hC0DE_0000 | k; run("R8");
    end
    for (int k = 1; k < 7; k++) begin
      go_mode("R8", MODES[k]);
      rd("R8", 4'd13, 4'd1);
    end

    // R9: user and system drop saved-status writes
    go_mode("R9", MODES[0]);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'hDEAD_BEEF; run("R9");
    go_mode("R9", MODES[7]);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'hFEED_FACE; run("R9");
    for (int k = 1; k < 7; k++) begin
      go_mode("R9", MODES[k]);
      rd("R9", 4'd0, 4'd0);
    end

    // R10: reserved mode maps to user copies
    go_mode("R10", 5'b00000);
    rd("R10", 4'd13, 4'd14);
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h0BAD_0013; run("R10");
    go_mode("R10", MODES[0]);
    rd("R10", 4'd13, 4'd8);

    // R11: writes in the mode-switch cycle land in the old bank
    psr_wr_en = 1'b1; psr_wr_data = {27'h0, MODES[2]};
    wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h0000_0077;
    run("R11");
    rd("R11", 4'd14, 4'd13);
    psr_wr_en = 1'b1; psr_wr_data = {27'h0, MODES[3]};
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h1111_2222;
    run("R11");
    go_mode("R11", MODES[2]);
    rd("R11", 4'd14, 4'd14);

    // R7 and R2: random traffic, full 32-bit status words
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m;
      m = MODES[$urandom_range(7)];
      if ($urandom_range(15) == 0) m = 5'($urandom);
      wr_en        = ($urandom_range(1) == 1);
      wr_idx       = 4'($urandom);
      wr_data      = $urandom;
      psr_wr_en    = ($urandom_range(5) == 0);
      psr_wr_data  = {27'($urandom), m};
      spsr_wr_en   = ($urandom_range(3) == 0);
      spsr_wr_data = $urandom;
      rd_a_idx     = ($urandom_range(3) == 0) ? wr_idx : 4'($urandom);
      rd_b_idx     = 4'($urandom);
      run(psr_wr_en ? "R7" : "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule